// File: doc/BRIEF.md
# Programmable Interval Timer with Free-Running Divider

This block is a small register-mapped timer for an 8-bit peripheral bus. A 16-bit divider advances on every system tick, and its upper byte can be read as a coarse time base. Beside it sits an 8-bit up-counter with a programmable reload value. The counter advances at one of four rates that are taken from the divider, and a 3-bit control field enables it.

When the counter passes its maximum value, it does not wrap to zero. It loads the reload value and raises a one-cycle interrupt request towards an external interrupt controller. Software reaches the four registers through a single offset/data port. Reads are combinational. Writes take effect at the next clock edge.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset the divider, counter, reload value and control field are zero, and the control register (offset 0x07) reads 0xF8. The interrupt output is low.
- R2: The divider increments by one at every clock edge where `tick` is high and holds otherwise. Offset 0x04 reads divider bits 15:8.
- R3: Any write to offset 0x04, whatever the data, clears the whole 16-bit divider to zero at the next edge. In that cycle the counter does not advance.
- R4: Control bits 1:0 select the counter period in ticks: 00 = 1024, 01 = 16, 10 = 64, 11 = 256. The counter advances on a tick whose incremented divider value has its low log2(period) bits all zero.
- R5: Control bit 2 enables the counter. While it is 0 the counter never advances.
- R6: When the counter advances from 0xFF it takes the reload value held before that edge. The interrupt output is high for exactly the one cycle in which the reloaded value is first visible.
- R7: Offset 0x05 is the counter, 0x06 the reload value and 0x07 the control register. A write to one of them is readable after the next edge. Control reads return bits 7:3 as 1. Other offsets read 0xFF and writes to them change nothing.
- R8: A write to the counter in the same cycle as an advance wins over the advance and suppresses any interrupt that advance would have raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Divider advance enable, one per system cycle |
| addr | input | 8 | Register offset for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| timerIrq | output | 1 | One-cycle interrupt request on counter reload |

## Verification
Every write and every tick lands one clock edge after it is presented, and register reads are combinational. The bench therefore drives inputs just after a falling edge and reads back at the next falling edge. A cycle-accurate model built from the requirements advances at the same edge and is compared at those points. The interrupt is due in the same cycle that the reloaded counter value first appears, so it is compared against the model after every single edge rather than only at row ends. Directed sequences pin absolute counts for each period, the reload boundary and a counter write that coincides with an advance.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 16;
  localparam int SEL_W  = 3;

  typedef struct packed {
    logic              divClear;
    logic              countLoad;
    logic              moduloLoad;
    logic              ctrlLoad;
    logic [DATA_W-1:0] data;
  } regStrobe_t;

  // mask of divider bits that must be zero for a counter step
  function automatic logic [DIV_W-1:0] periodMask(input logic [1:0] sel);
    logic [DIV_W-1:0] m;
    case (sel)
      2'b00:   m = DIV_W'(1023);
      2'b01:   m = DIV_W'(15);
      2'b10:   m = DIV_W'(63);
      default: m = DIV_W'(255);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DIV_OFS = 4,
  parameter int CNT_OFS = 5,
  parameter int MOD_OFS = 6,
  parameter int CTL_OFS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] divHigh,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] modulo,
  input  logic [SEL_W-1:0]  ctrlReg,
  output regStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData
);
  localparam int PAD_W = DATA_W - SEL_W;

  logic hitDiv, hitCnt, hitMod, hitCtl;

  always_comb begin
    hitDiv = (addr == ADDR_W'(DIV_OFS));
    hitCnt = (addr == ADDR_W'(CNT_OFS));
    hitMod = (addr == ADDR_W'(MOD_OFS));
    hitCtl = (addr == ADDR_W'(CTL_OFS));
  end

  always_comb begin
    strobe.divClear   = wrEn && hitDiv;
    strobe.countLoad  = wrEn && hitCnt;
    strobe.moduloLoad = wrEn && hitMod;
    strobe.ctrlLoad   = wrEn && hitCtl;
    strobe.data       = wrData;
  end

  always_comb begin
    if (hitDiv)      rdData = divHigh;
    else if (hitCnt) rdData = count;
    else if (hitMod) rdData = modulo;
    else if (hitCtl) rdData = {{PAD_W{1'b1}}, ctrlReg};
    else             rdData = '1;
  end

  // R7
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.divClear, strobe.countLoad, strobe.moduloLoad, strobe.ctrlLoad}))
    else $error("strobe_onehot_chk");
endmodule

// File: rtl/tick_timer_datapath.sv
module tick_timer_datapath
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  regStrobe_t        strobe,
  output logic [DIV_W-1:0]  divCount,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] modulo,
  output logic [SEL_W-1:0]  ctrlReg,
  output logic              irq
);
  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  logic [DIV_W-1:0] divNext;
  logic             stepHit;
  logic             stepCnt;

  always_comb begin
    divNext = divCount + DIV_W'(1);
    stepHit = ((divNext & periodMask(ctrlReg[1:0])) == '0);
    stepCnt = tick && ctrlReg[2] && !strobe.divClear && stepHit;
  end

  always_ff @(posedge clk) begin
    if (rst)                  divCount <= '0;
    else if (strobe.divClear) divCount <= '0;
    else if (tick)            divCount <= divNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modulo  <= '0;
      ctrlReg <= '0;
    end else begin
      if (strobe.moduloLoad) modulo  <= strobe.data;
      if (strobe.ctrlLoad)   ctrlReg <= strobe.data[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      irq   <= 1'b0;
    end else if (strobe.countLoad) begin
      count <= strobe.data;
      irq   <= 1'b0;
    end else if (stepCnt && count == CNT_MAX) begin
      count <= modulo;
      irq   <= 1'b1;
    end else begin
      if (stepCnt) count <= count + DATA_W'(1);
      irq <= 1'b0;
    end
  end

  // R2
  div_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !strobe.divClear) |=> divCount == $past(divCount) + DIV_W'(1))
    else $error("div_adv_chk");

  // R3
  div_clr_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.divClear |=> divCount == '0)
    else $error("div_clr_chk");

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrlReg[2] && !strobe.countLoad) |=> $stable(count))
    else $error("count_hold_chk");

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq)
    else $error("irq_pulse_chk");

  // R6
  reload_val_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> count == $past(modulo))
    else $error("reload_val_chk");
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DIV_OFS = 4,
  parameter int CNT_OFS = 5,
  parameter int MOD_OFS = 6,
  parameter int CTL_OFS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              timerIrq
);
  regStrobe_t        strobe;
  logic [DIV_W-1:0]  divCount;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] modulo;
  logic [SEL_W-1:0]  ctrlReg;

  tick_timer_ctrl #(
    .ADDR_W(ADDR_W), .DIV_OFS(DIV_OFS), .CNT_OFS(CNT_OFS),
    .MOD_OFS(MOD_OFS), .CTL_OFS(CTL_OFS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .divHigh(divCount[DIV_W-1 -: DATA_W]), .count(count), .modulo(modulo),
    .ctrlReg(ctrlReg), .strobe(strobe), .rdData(rdData)
  );

  tick_timer_datapath u_dp (
    .clk(clk), .rst(rst), .tick(tick), .strobe(strobe),
    .divCount(divCount), .count(count), .modulo(modulo),
    .ctrlReg(ctrlReg), .irq(timerIrq)
  );
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       timerIrq;

  int checks = 0;
  int errors = 0;
  int irqBad = 0;

  // requirement-level model state
  logic [15:0] mDiv;
  logic [7:0]  mCnt, mMod;
  logic [2:0]  mCtl;
  logic        mIrq;

  tick_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .timerIrq(timerIrq)
  );

  always #5 clk = ~clk;

  // row: wr, offset, data, ticks to run afterwards
  typedef struct packed {
    logic       wr;
    logic [7:0] ofs;
    logic [7:0] data;
    logic [15:0] run;
  } row_t;

  localparam int NROWS = 11;
  localparam row_t TABLE [NROWS] = '{
    '{1'b1, 8'h04, 8'h5A, 16'd100},
    '{1'b1, 8'h06, 8'hF0, 16'd10},
    '{1'b1, 8'h05, 8'hFE, 16'd5},
    '{1'b1, 8'h07, 8'h05, 16'd40},
    '{1'b1, 8'h07, 8'h06, 16'd300},
    '{1'b1, 8'h07, 8'h07, 16'd600},
    '{1'b1, 8'h07, 8'h04, 16'd2100},
    '{1'b1, 8'h07, 8'h01, 16'd300},
    '{1'b1, 8'h10, 8'hAB, 16'd3},
    '{1'b1, 8'h06, 8'h00, 16'd20},
    '{1'b1, 8'h07, 8'hFD, 16'd50}
  };

  function automatic logic [15:0] maskOf(input logic [1:0] s);
    case (s)
      2'b00: return 16'd1023;
      2'b01: return 16'd15;
      2'b10: return 16'd63;
      default: return 16'd255;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic readChk(input string req, input logic [7:0] ofs, input logic [7:0] exp);
    addr = ofs;
    #1;
    check(req, rdData, exp);
  endtask

  // one clock cycle, entered and left at a falling edge
  task automatic cycle(input logic t, input logic w, input logic [7:0] ofs, input logic [7:0] d);
    logic [15:0] nDiv;
    logic [7:0]  nCnt;
    logic        nIrq, step, divW;
    tick = t; wrEn = w; addr = ofs; wrData = d;
    divW = w && ofs == 8'h04;
    nDiv = divW ? 16'h0 : (t ? mDiv + 16'd1 : mDiv);
    step = t && mCtl[2] && !divW && (((mDiv + 16'd1) & maskOf(mCtl[1:0])) == 16'h0);
    nCnt = mCnt; nIrq = 1'b0;
    if (w && ofs == 8'h05) nCnt = d;
    else if (step && mCnt == 8'hFF) begin nCnt = mMod; nIrq = 1'b1; end
    else if (step) nCnt = mCnt + 8'd1;
    @(posedge clk);
    mDiv = nDiv; mCnt = nCnt; mIrq = nIrq;
    if (w && ofs == 8'h06) mMod = d;
    if (w && ofs == 8'h07) mCtl = d[2:0];
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    if (timerIrq !== mIrq) begin
      irqBad++;
    end
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic modelChk(input string req);
    readChk(req, 8'h04, mDiv[15:8]);
    readChk(req, 8'h05, mCnt);
    readChk(req, 8'h06, mMod);
    readChk(req, 8'h07, {5'b11111, mCtl});
    checks++;
    if (irqBad != 0) begin
      errors++;
      $display("FAIL %s irq trace: actual mismatches=%0d expected=0", req, irqBad);
      irqBad = 0;
    end
  endtask

  // set up a known phase: divider 0, counter value, period select; no ticks
  task automatic arm(input logic [7:0] cnt, input logic [7:0] ctl);
    cycle(1'b0, 1'b1, 8'h04, 8'h00);
    cycle(1'b0, 1'b1, 8'h05, cnt);
    cycle(1'b0, 1'b1, 8'h07, ctl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    mDiv = '0; mCnt = '0; mMod = '0; mCtl = '0; mIrq = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    readChk("R1 div", 8'h04, 8'h00);
    readChk("R1 cnt", 8'h05, 8'h00);
    readChk("R1 mod", 8'h06, 8'h00);
    readChk("R1 ctl", 8'h07, 8'hF8);
    check("R1 irq", {7'd0, timerIrq}, 8'h00);
    readChk("R7 unmapped", 8'h33, 8'hFF);

    // table walk against the model (R4, R6, R7, R5)
    for (int r = 0; r < NROWS; r++) begin
      cycle(1'b0, TABLE[r].wr, TABLE[r].ofs, TABLE[r].data);
      runTicks(int'(TABLE[r].run));
      modelChk($sformatf("R7 row%0d", r));
    end

    // R2 tick gating and upper-byte view
    cycle(1'b0, 1'b1, 8'h07, 8'h00);
    cycle(1'b0, 1'b1, 8'h04, 8'h77);
    runTicks(300);
    readChk("R2 div after 300", 8'h04, 8'h01);
    for (int i = 0; i < 60; i++) cycle(1'b0, 1'b0, 8'h00, 8'h00);
    readChk("R2 div held", 8'h04, 8'h01);
    runTicks(212);
    readChk("R2 div after 512", 8'h04, 8'h02);

    // R3 clear
    cycle(1'b1, 1'b1, 8'h04, 8'hFF);
    readChk("R3 div cleared", 8'h04, 8'h00);
    runTicks(255);
    readChk("R3 low byte cleared too", 8'h04, 8'h00);

    // R4 each period
    arm(8'h00, 8'h05); runTicks(160);  readChk("R4 period16", 8'h05, 8'd10);
    arm(8'h00, 8'h06); runTicks(640);  readChk("R4 period64", 8'h05, 8'd10);
    arm(8'h00, 8'h07); runTicks(1024); readChk("R4 period256", 8'h05, 8'd4);
    arm(8'h00, 8'h04); runTicks(2048); readChk("R4 period1024", 8'h05, 8'd2);

    // R5 disabled
    arm(8'h42, 8'h01); runTicks(500); readChk("R5 disabled", 8'h05, 8'h42);

    // R6 reload boundary with irq timing
    cycle(1'b0, 1'b1, 8'h06, 8'h80);
    arm(8'hFF, 8'h05);
    runTicks(15);
    readChk("R6 before overflow", 8'h05, 8'hFF);
    check("R6 irq low before", {7'd0, timerIrq}, 8'h00);
    runTicks(1);
    readChk("R6 reloaded", 8'h05, 8'h80);
    check("R6 irq high", {7'd0, timerIrq}, 8'h01);
    runTicks(1);
    check("R6 irq one cycle", {7'd0, timerIrq}, 8'h00);
    readChk("R6 after", 8'h05, 8'h80);

    // R8 write coinciding with overflow step
    arm(8'hFF, 8'h05);
    runTicks(15);
    cycle(1'b1, 1'b1, 8'h05, 8'h33);
    readChk("R8 write wins", 8'h05, 8'h33);
    check("R8 irq suppressed", {7'd0, timerIrq}, 8'h00);

    // R7 ignored write offset and control upper bits
    cycle(1'b0, 1'b1, 8'h08, 8'h00);
    modelChk("R7 ignored offset");
    readChk("R7 ctl pad", 8'h07, 8'hFD);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule